// File: doc/BRIEF.md
# DMA Physical Address Generator

This block sits beside the register file of a pair of cascaded four-channel DMA controllers and turns the programmed per-channel state into what a transfer engine needs. It does three jobs. It picks which requesting channel to serve. It reports where that channel stands in its block and how long the whole block is. For any piece of that block, given as a byte offset and a length, it forms the 32-bit physical start address and says in which element order the data must be delivered. A fourth path converts a byte position reported back by the engine into the value for the channel's current-count register.

Each controller is either byte-wide or word-wide, set by a parameter. On a word-wide controller the 16-bit address and counts are in words and are scaled to bytes. The page byte's bit 0 is then ignored, because the scaled address already supplies physical bit 16. An optional high page byte supplies physical bits 31:24. When the high pages are configured out, those bits read as zero. Every request is a single-cycle strobe, and the answer appears one clock later with a one-cycle valid pulse.

Top module: `dma_ag_top`

## Requirements
- R1: After reset, all valid pulses and the no-channel pulse are low, and every data output is zero.
- R2: A channel can be chosen only when its controller's enable bit is 1, its mask bit is 0 and its request bit is 1.
- R3: Among the channels that can be chosen, the one with the lowest global number wins. The global number is controller index times 4 plus the channel index, so every channel of controller 0 beats every channel of controller 1. The chosen number appears on `xfer_ch_o`.
- R4: A service strobe that finds no channel it can choose raises `svc_none_o` for one cycle and leaves `xfer_vld_o` low.
- R5: `xfer_pos_o` is the chosen channel's current count, shifted left by one on a word-wide controller.
- R6: `xfer_total_o` is (base count + 1), shifted left by one on a word-wide controller. Base 0xFFFF gives 0x10000 bytes on a byte-wide controller and 0x20000 bytes on a word-wide one.
- R7: The channel base address is the high page in bits 31:24 plus the page in bits 23:16 plus the current address, where the current address is shifted left by one on a word-wide controller. On a word-wide controller, page bit 0 is cleared before use. In increment mode (direction bit 0), the block start address is the base plus the offset, modulo 2^32.
- R8: In decrement mode (direction bit 1), the block start address is base − offset − length, modulo 2^32, and `blk_rev_o` is 1 so that the data is delivered in reversed element order.
- R9: With `HIPAGE_EN` = 0, the high page inputs have no effect and are treated as zero.
- R10: A count write-back returns the reported byte position, shifted right by one on a word-wide controller, truncated to 16 bits.
- R11: Each of `xfer_vld_o`, `blk_vld_o` and `cnt_vld_o` is high for exactly the one cycle after its strobe. `blk_wide_o` is 1 when the element is a 16-bit word. By default, channels 4 to 7 are word-wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en_i | input | 2 | Enable per controller |
| mask_i | input | 8 | Mask bit per channel (1 = masked) |
| dreq_i | input | 8 | Request status per channel |
| mode_dec_i | input | 8 | Direction per channel (1 = decrement) |
| cur_addr_i | input | 128 | Current address, 16 bits per channel |
| cur_cnt_i | input | 128 | Current count, 16 bits per channel |
| base_cnt_i | input | 128 | Base count, 16 bits per channel |
| page_i | input | 64 | Page byte per channel |
| hipage_i | input | 64 | High page byte per channel |
| svc_go_i | input | 1 | Strobe: choose a channel |
| xfer_vld_o | output | 1 | Channel chosen, results valid |
| svc_none_o | output | 1 | Strobe found no channel |
| xfer_ch_o | output | 3 | Global number of the chosen channel |
| xfer_pos_o | output | 32 | Starting byte position |
| xfer_total_o | output | 32 | Total block length in bytes |
| blk_go_i | input | 1 | Strobe: form a block address |
| blk_ch_i | input | 3 | Channel for the block |
| blk_off_i | input | 32 | Byte offset of the block |
| blk_len_i | input | 32 | Byte length of the block |
| blk_vld_o | output | 1 | Block address valid |
| blk_addr_o | output | 32 | Physical start address |
| blk_rev_o | output | 1 | Deliver in reversed element order |
| blk_wide_o | output | 1 | Element is a 16-bit word |
| cnt_go_i | input | 1 | Strobe: convert a returned position |
| cnt_ch_i | input | 3 | Channel for the write-back |
| cnt_pos_i | input | 32 | Returned byte position |
| cnt_vld_o | output | 1 | New count valid |
| cnt_new_o | output | 16 | New current-count value |

## Verification
A wrong width flag or a wrong page mask shows up on the very next cycle after a block strobe. It appears as a block address off by a factor of two or by 64 KiB. It also appears as a total length off by a factor of two for the channels of one controller only. A wrong priority order or a wrong eligibility term shows the same cycle as a wrong channel number or a stray no-channel pulse. It appears only when two or more channels request at once, or when a request is masked or its controller disabled. For that reason, the stimulus mixes requests across both controllers.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  localparam int CNT_W  = 16;
  localparam int PAGE_W = 8;
  localparam int PHYS_W = 32;

  typedef struct packed {
    logic [CNT_W-1:0]  addr;
    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] hipage;
    logic              dec;
    logic              wide;
  } chan_loc_t;
endpackage

// File: rtl/dma_ag_arbiter.sv
module dma_ag_arbiter #(
  parameter int NCTL = 2,
  parameter int CPC  = 4,
  localparam int NCH  = NCTL * CPC,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [NCTL-1:0] ctl_en_i,
  input  logic [NCH-1:0]  mask_i,
  input  logic [NCH-1:0]  dreq_i,
  output logic [NCH-1:0]  elig_o,
  output logic            any_o,
  output logic [CH_W-1:0] idx_o
);
  // Eligibility per channel: controller on, unmasked, requesting
  for (genvar c = 0; c < NCH; c++) begin : g_elig
    assign elig_o[c] = ctl_en_i[c / CPC] & ~mask_i[c] & dreq_i[c];
  end

  // Lowest global number wins (controller 0 before controller 1)
  always_comb begin
    idx_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (elig_o[c]) idx_o = CH_W'(c);
    end
  end

  assign any_o = |elig_o;
endmodule

// File: rtl/dma_ag_xfer.sv
module dma_ag_xfer
  import dma_ag_pkg::*;
#(
  parameter int NCH  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              any_i,
  input  logic [NCH-1:0]    elig_i,
  input  logic [CH_W-1:0]   idx_i,
  input  logic [CNT_W-1:0]  cur_cnt_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic              wide_i,
  output logic              vld_o,
  output logic              none_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [PHYS_W-1:0] pos_o,
  output logic [PHYS_W-1:0] total_o
);
  logic              vld_d, none_d, load;
  logic [PHYS_W-1:0] pos_d, total_d;

  always_comb begin
    vld_d   = go_i & any_i;
    none_d  = go_i & ~any_i;
    load    = vld_d;
    pos_d   = PHYS_W'(cur_cnt_i) << wide_i;
    total_d = (PHYS_W'(base_cnt_i) + PHYS_W'(1)) << wide_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o   <= 1'b0;
      none_o  <= 1'b0;
      ch_o    <= '0;
      pos_o   <= '0;
      total_o <= '0;
    end else begin
      vld_o  <= vld_d;
      none_o <= none_d;
      if (load) begin
        ch_o    <= idx_i;
        pos_o   <= pos_d;
        total_o <= total_d;
      end
    end
  end

  // R2: the chosen channel was eligible when the strobe was taken
  p_elig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(elig_i[idx_i]));
  // R3: no lower-numbered channel was eligible
  p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (($past(elig_i) & ~({NCH{1'b1}} << ch_o)) == '0));
  // R4: the no-channel pulse only when nothing was eligible
  p_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    none_o |-> ($past(elig_i) == '0));
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_o && none_o));
endmodule

// File: rtl/dma_ag_addr.sv
module dma_ag_addr
  import dma_ag_pkg::*;
#(
  parameter bit HIPAGE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  chan_loc_t         loc_i,
  input  logic [PHYS_W-1:0] off_i,
  input  logic [PHYS_W-1:0] len_i,
  output logic              vld_o,
  output logic [PHYS_W-1:0] addr_o,
  output logic              rev_o,
  output logic              wide_o
);
  logic [PAGE_W-1:0] page_eff, hi_eff;
  logic [PHYS_W-1:0] base_c, addr_d;

  // Optional high page: forced to zero when configured out
  if (HIPAGE_EN) begin : g_hi
    assign hi_eff = loc_i.hipage;
  end else begin : g_nohi
    assign hi_eff = loc_i.hipage & '0;
  end

  always_comb begin
    page_eff = loc_i.wide ? {loc_i.page[PAGE_W-1:1], 1'b0} : loc_i.page;
    base_c   = (PHYS_W'({hi_eff, page_eff}) << CNT_W)
             + (PHYS_W'(loc_i.addr) << loc_i.wide);
    addr_d   = loc_i.dec ? (base_c - off_i - len_i) : (base_c + off_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      rev_o  <= 1'b0;
      wide_o <= 1'b0;
    end else begin
      vld_o <= go_i;
      if (go_i) begin
        addr_o <= addr_d;
        rev_o  <= loc_i.dec;
        wide_o <= loc_i.wide;
      end
    end
  end

  // R7: word channels with even offsets and lengths stay word aligned
  p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && wide_o && !$past(off_i[0]) && !$past(len_i[0])) |-> !addr_o[0]);
  // R11: the block result is a one-cycle answer to a strobe
  p_blk_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(go_i));
endmodule

// File: rtl/dma_ag_cnt.sv
module dma_ag_cnt
  import dma_ag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              wide_i,
  input  logic [PHYS_W-1:0] pos_i,
  output logic              vld_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [PHYS_W-1:0] scaled;

  always_comb scaled = pos_i >> wide_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      vld_o <= go_i;
      if (go_i) cnt_o <= scaled[CNT_W-1:0];
    end
  end

  // R10: a converted count only follows a write-back strobe
  p_cnt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(go_i));
  // R10: on byte channels the low bits pass straight through
  p_cnt_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !$past(wide_i)) |-> (cnt_o == $past(pos_i[CNT_W-1:0])));
endmodule

// File: rtl/dma_ag_top.sv
module dma_ag_top
  import dma_ag_pkg::*;
#(
  parameter int           NCTL      = 2,
  parameter int           CPC       = 4,
  parameter logic [1:0]   WIDE_CTL  = 2'b10,
  parameter bit           HIPAGE_EN = 1'b1,
  localparam int NCH  = NCTL * CPC,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCTL-1:0]       ctl_en_i,
  input  logic [NCH-1:0]        mask_i,
  input  logic [NCH-1:0]        dreq_i,
  input  logic [NCH-1:0]        mode_dec_i,
  input  logic [NCH*CNT_W-1:0]  cur_addr_i,
  input  logic [NCH*CNT_W-1:0]  cur_cnt_i,
  input  logic [NCH*CNT_W-1:0]  base_cnt_i,
  input  logic [NCH*PAGE_W-1:0] page_i,
  input  logic [NCH*PAGE_W-1:0] hipage_i,
  input  logic                  svc_go_i,
  output logic                  xfer_vld_o,
  output logic                  svc_none_o,
  output logic [CH_W-1:0]       xfer_ch_o,
  output logic [PHYS_W-1:0]     xfer_pos_o,
  output logic [PHYS_W-1:0]     xfer_total_o,
  input  logic                  blk_go_i,
  input  logic [CH_W-1:0]       blk_ch_i,
  input  logic [PHYS_W-1:0]     blk_off_i,
  input  logic [PHYS_W-1:0]     blk_len_i,
  output logic                  blk_vld_o,
  output logic [PHYS_W-1:0]     blk_addr_o,
  output logic                  blk_rev_o,
  output logic                  blk_wide_o,
  input  logic                  cnt_go_i,
  input  logic [CH_W-1:0]       cnt_ch_i,
  input  logic [PHYS_W-1:0]     cnt_pos_i,
  output logic                  cnt_vld_o,
  output logic [CNT_W-1:0]      cnt_new_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // Per-channel width flag from the owning controller
  logic [NCH-1:0] wide_vec;
  for (genvar c = 0; c < NCH; c++) begin : g_wide
    assign wide_vec[c] = WIDE_CTL[c / CPC];
  end

  // Channel selection
  logic [NCH-1:0]  elig;
  logic            any;
  logic [CH_W-1:0] sel_idx;

  dma_ag_arbiter #(.NCTL(NCTL), .CPC(CPC)) u_arb (
    .ctl_en_i (ctl_en_i),
    .mask_i   (mask_i),
    .dreq_i   (dreq_i),
    .elig_o   (elig),
    .any_o    (any),
    .idx_o    (sel_idx)
  );

  dma_ag_xfer #(.NCH(NCH)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_q),
    .go_i       (svc_go_i),
    .any_i      (any),
    .elig_i     (elig),
    .idx_i      (sel_idx),
    .cur_cnt_i  (cur_cnt_i[sel_idx*CNT_W +: CNT_W]),
    .base_cnt_i (base_cnt_i[sel_idx*CNT_W +: CNT_W]),
    .wide_i     (wide_vec[sel_idx]),
    .vld_o      (xfer_vld_o),
    .none_o     (svc_none_o),
    .ch_o       (xfer_ch_o),
    .pos_o      (xfer_pos_o),
    .total_o    (xfer_total_o)
  );

  // Block address path
  chan_loc_t blk_loc;
  always_comb begin
    blk_loc.addr   = cur_addr_i[blk_ch_i*CNT_W +: CNT_W];
    blk_loc.page   = page_i[blk_ch_i*PAGE_W +: PAGE_W];
    blk_loc.hipage = hipage_i[blk_ch_i*PAGE_W +: PAGE_W];
    blk_loc.dec    = mode_dec_i[blk_ch_i];
    blk_loc.wide   = wide_vec[blk_ch_i];
  end

  dma_ag_addr #(.HIPAGE_EN(HIPAGE_EN)) u_addr (
    .clk    (clk),
    .rst_n  (rst_q),
    .go_i   (blk_go_i),
    .loc_i  (blk_loc),
    .off_i  (blk_off_i),
    .len_i  (blk_len_i),
    .vld_o  (blk_vld_o),
    .addr_o (blk_addr_o),
    .rev_o  (blk_rev_o),
    .wide_o (blk_wide_o)
  );

  // Count write-back path
  dma_ag_cnt u_cnt (
    .clk    (clk),
    .rst_n  (rst_q),
    .go_i   (cnt_go_i),
    .wide_i (wide_vec[cnt_ch_i]),
    .pos_i  (cnt_pos_i),
    .vld_o  (cnt_vld_o),
    .cnt_o  (cnt_new_o)
  );

  // R11: service results answer a strobe, one cycle late
  p_svc_pulse_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (xfer_vld_o || svc_none_o) |-> $past(svc_go_i));
  // R8: decrement direction drives reversed delivery
  p_rev_r8: assert property (@(posedge clk) disable iff (!rst_q)
    blk_vld_o |-> (blk_rev_o == $past(mode_dec_i[blk_ch_i])));
endmodule

// File: tb/dma_ag_top_test.sv
module dma_ag_top_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [1:0]    ctl_en;
  logic [7:0]    mask, dreq, dec;
  logic [127:0]  cur_addr, cur_cnt, base_cnt;
  logic [63:0]   page, hipage;
  logic          svc_go, blk_go, cnt_go;
  logic [2:0]    blk_ch, cnt_ch;
  logic [31:0]   blk_off, blk_len, cnt_pos;

  logic          xfer_vld, svc_none, blk_vld, blk_rev, blk_wide, cnt_vld;
  logic [2:0]    xfer_ch;
  logic [31:0]   xfer_pos, xfer_total, blk_addr;
  logic [15:0]   cnt_new;
  logic          n_xv, n_sn, n_bv, n_br, n_bw, n_cv;
  logic [2:0]    n_xc;
  logic [31:0]   n_xp, n_xt, n_ba;
  logic [15:0]   n_cn;

  int checks = 0;
  int fails  = 0;

  dma_ag_top uut (
    .clk(clk), .rst_n(rst_n), .ctl_en_i(ctl_en), .mask_i(mask), .dreq_i(dreq),
    .mode_dec_i(dec), .cur_addr_i(cur_addr), .cur_cnt_i(cur_cnt),
    .base_cnt_i(base_cnt), .page_i(page), .hipage_i(hipage),
    .svc_go_i(svc_go), .xfer_vld_o(xfer_vld), .svc_none_o(svc_none),
    .xfer_ch_o(xfer_ch), .xfer_pos_o(xfer_pos), .xfer_total_o(xfer_total),
    .blk_go_i(blk_go), .blk_ch_i(blk_ch), .blk_off_i(blk_off), .blk_len_i(blk_len),
    .blk_vld_o(blk_vld), .blk_addr_o(blk_addr), .blk_rev_o(blk_rev),
    .blk_wide_o(blk_wide), .cnt_go_i(cnt_go), .cnt_ch_i(cnt_ch),
    .cnt_pos_i(cnt_pos), .cnt_vld_o(cnt_vld), .cnt_new_o(cnt_new)
  );

  dma_ag_top #(.HIPAGE_EN(1'b0)) uut_nohi (
    .clk(clk), .rst_n(rst_n), .ctl_en_i(ctl_en), .mask_i(mask), .dreq_i(dreq),
    .mode_dec_i(dec), .cur_addr_i(cur_addr), .cur_cnt_i(cur_cnt),
    .base_cnt_i(base_cnt), .page_i(page), .hipage_i(hipage),
    .svc_go_i(svc_go), .xfer_vld_o(n_xv), .svc_none_o(n_sn),
    .xfer_ch_o(n_xc), .xfer_pos_o(n_xp), .xfer_total_o(n_xt),
    .blk_go_i(blk_go), .blk_ch_i(blk_ch), .blk_off_i(blk_off), .blk_len_i(blk_len),
    .blk_vld_o(n_bv), .blk_addr_o(n_ba), .blk_rev_o(n_br),
    .blk_wide_o(n_bw), .cnt_go_i(cnt_go), .cnt_ch_i(cnt_ch),
    .cnt_pos_i(cnt_pos), .cnt_vld_o(n_cv), .cnt_new_o(n_cn)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic        dec;
    logic [15:0] a;
    logic [7:0]  pg;
    logic [7:0]  hi;
    logic [31:0] off;
    logic [31:0] len;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 16'h1234, 8'h56, 8'h78, 32'h10, 32'h4, 32'h7856_1244},
    '{3'd2, 1'b1, 16'h1000, 8'h02, 8'h00, 32'h20, 32'h10, 32'h0002_0FD0},
    '{3'd5, 1'b0, 16'h8001, 8'h13, 8'hAB, 32'h6, 32'h2, 32'hAB13_0008},
    '{3'd7, 1'b1, 16'h0004, 8'h01, 8'h01, 32'h2, 32'h8, 32'h00FF_FFFE},
    '{3'd0, 1'b0, 16'hFFFF, 8'hFF, 8'hFF, 32'h1, 32'h1, 32'h0000_0000},
    '{3'd4, 1'b0, 16'hFFFF, 8'h00, 8'h00, 32'h0, 32'h2, 32'h0001_FFFE},
    '{3'd6, 1'b1, 16'h0000, 8'h02, 8'h00, 32'h0, 32'h2, 32'h0001_FFFE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic svc(input logic [1:0] en, input logic [7:0] m, input logic [7:0] r);
    @(negedge clk);
    ctl_en = en; mask = m; dreq = r; svc_go = 1'b1;
    @(negedge clk);
    svc_go = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_en = '0; mask = '1; dreq = '0; dec = '0;
    cur_addr = '0; cur_cnt = '0; base_cnt = '0; page = '0; hipage = '0;
    svc_go = 0; blk_go = 0; cnt_go = 0; blk_ch = 0; cnt_ch = 0;
    blk_off = 0; blk_len = 0; cnt_pos = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 xfer_vld", 32'(xfer_vld), 0);
    chk("R1 svc_none", 32'(svc_none), 0);
    chk("R1 blk_vld", 32'(blk_vld), 0);
    chk("R1 cnt_vld", 32'(cnt_vld), 0);
    chk("R1 blk_addr", blk_addr, 0);
    chk("R1 xfer_total", xfer_total, 0);

    // R7 R8 R11 table of block address vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cur_addr[VECS[i].ch*16 +: 16] = VECS[i].a;
      page[VECS[i].ch*8 +: 8]       = VECS[i].pg;
      hipage[VECS[i].ch*8 +: 8]     = VECS[i].hi;
      dec[VECS[i].ch]               = VECS[i].dec;
      blk_ch = VECS[i].ch; blk_off = VECS[i].off; blk_len = VECS[i].len;
      blk_go = 1'b1;
      @(negedge clk);
      blk_go = 1'b0;
      chk("R11 blk_vld", 32'(blk_vld), 1);
      chk(VECS[i].dec ? "R8 blk_addr" : "R7 blk_addr", blk_addr, VECS[i].exp);
      chk("R8 blk_rev", 32'(blk_rev), 32'(VECS[i].dec));
      chk("R11 blk_wide", 32'(blk_wide), 32'(VECS[i].ch >= 3'd4));
      if (i == 0) chk("R9 nohi inc", n_ba, 32'h0056_1244);
      if (i == 3) chk("R9 nohi dec", n_ba, 32'hFFFF_FFFE);
      @(negedge clk);
      chk("R11 blk pulse ends", 32'(blk_vld), 0);
    end

    // R5 R6 counts for the channels used below
    cur_cnt[3*16 +: 16] = 16'h0100; base_cnt[3*16 +: 16] = 16'h00FF;
    cur_cnt[5*16 +: 16] = 16'h8000; base_cnt[5*16 +: 16] = 16'hFFFF;
    cur_cnt[0 +: 16]    = 16'h0007; base_cnt[0 +: 16]    = 16'hFFFF;

    // R3 all requesting: channel 0 wins
    svc(2'b11, 8'h00, 8'hFF);
    chk("R3 xfer_vld", 32'(xfer_vld), 1);
    chk("R3 all req ch", 32'(xfer_ch), 0);
    chk("R5 pos byte", xfer_pos, 32'h7);
    chk("R6 total byte max", xfer_total, 32'h0001_0000);
    @(negedge clk);
    chk("R11 xfer pulse ends", 32'(xfer_vld), 0);

    // R2 mask of channel 0 moves to channel 1
    svc(2'b11, 8'h01, 8'hFF);
    chk("R2 masked ch0", 32'(xfer_ch), 1);

    // R2 controller 0 disabled: channel 4
    svc(2'b10, 8'h00, 8'hFF);
    chk("R2 ctl0 off", 32'(xfer_ch), 4);

    // R3 controller 0 channel 3 beats controller 1 channel 5
    svc(2'b11, 8'h00, 8'h28);
    chk("R3 ctl order", 32'(xfer_ch), 3);
    chk("R5 pos ch3", xfer_pos, 32'h100);
    chk("R6 total ch3", xfer_total, 32'h100);

    // R5 R6 word controller
    svc(2'b11, 8'h00, 8'h20);
    chk("R3 ch5", 32'(xfer_ch), 5);
    chk("R5 pos word", xfer_pos, 32'h0001_0000);
    chk("R6 total word max", xfer_total, 32'h0002_0000);

    // R4 only request is masked: no channel
    svc(2'b11, 8'h40, 8'h40);
    chk("R4 svc_none", 32'(svc_none), 1);
    chk("R4 xfer_vld low", 32'(xfer_vld), 0);
    // R4 request on disabled controller
    svc(2'b01, 8'h00, 8'h10);
    chk("R4 disabled ctl none", 32'(svc_none), 1);

    // R10 count write-back
    @(negedge clk); cnt_ch = 3'd2; cnt_pos = 32'h1234; cnt_go = 1'b1;
    @(negedge clk); cnt_go = 1'b0;
    chk("R10 byte count", 32'(cnt_new), 32'h1234);
    chk("R11 cnt_vld", 32'(cnt_vld), 1);
    @(negedge clk); cnt_ch = 3'd6; cnt_pos = 32'h2468; cnt_go = 1'b1;
    @(negedge clk); cnt_go = 1'b0;
    chk("R10 word count", 32'(cnt_new), 32'h1234);
    @(negedge clk); cnt_ch = 3'd4; cnt_pos = 32'h0002_0000; cnt_go = 1'b1;
    @(negedge clk); cnt_go = 1'b0;
    chk("R10 word wrap", 32'(cnt_new), 32'h0);
    @(negedge clk);
    chk("R11 cnt pulse ends", 32'(cnt_vld), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule